// File: doc/BRIEF.md
# Sensor-Bus Client Command Responder

This block is the reply side of a client on a single-wire platform management bus. Bit framing has already been done upstream. Each decoded request arrives as a one-cycle strobe with these fields:

- the command byte
- the declared write and read lengths
- the write payload bytes
- a flag that says whether the request's own frame check sequence (FCS) was good

At the same time a back end offers the reply data and a data-ready level.

From this the block decides whether the reply is normal or aborted. It picks a completion code for commands that carry one and computes the FCS byte to send. An error is never reported through a status field. The client instead sends an FCS that is deliberately wrong, so the originator always sees a broken reply.

Command codes carry a domain in their two low bits. A build parameter chooses whether the second domain is served. For the two write commands, the block verifies an assured-write checksum that the originator appends to the payload.

Top module: `sbr_responder`

## Requirements
- R1: `resp_valid` is high for exactly the one cycle after a cycle with `frame_valid` high, and low otherwise. The other outputs are updated only on that edge and hold their values between replies. Synchronous reset drives every output to zero.
- R2: `cmd_code[1:0]` is the domain field (01 = domain 0, 10 = domain 1). `cmd_code[7:2]` selects the command. The accepted codes, domain 0 / domain 1, are:
  - temperature read 0x01/0x02
  - config read 0xC1/0xC2
  - config write 0xC5/0xC6
  - mailbox send 0xD1/0xD2
  - mailbox get 0xD5/0xD6

  Any other code is aborted, with `resp_has_cc`=0, no reply bytes and `resp_domain`=0.
- R3: `resp_domain` is 1 for an accepted domain-1 code and 0 otherwise. With `DUAL_DOMAIN`=0, all domain-1 codes count as unrecognised.
- R4: Each command requires an exact (write length, read length) pair; any other pair is aborted. The lengths count the command byte and the completion code:
  - temperature read (1,2)
  - config read (5,5)
  - config write (7,1)
  - mailbox send (7,1)
  - mailbox get (2,5)
- R5: `data_ready` is sampled in the `frame_valid` cycle. If it is low for a read-type command (temperature, config read, mailbox get), the reply is aborted. For write commands it has no effect.
- R6: For config write and mailbox send, payload byte 5 (`wr_data[47:40]`) must equal the CRC of the command byte followed by payload bytes 0 to 4. Otherwise the reply is aborted, even if everything else is well formed.
- R7: A request with `frame_fcs_ok` low is aborted.
- R8: Every recognised command except temperature read carries a completion code. It is 0x40 on success and 0x80 on abort, so bit 7 marks failure. When there is no code, `resp_cc` is 0x00.
- R9: The reply bytes are the completion code (if present), then `rd_data` bytes 0, 1, ... (byte k at bits 8k+7:8k). The total count is the command's required read length. `resp_fcs` is the CRC-8 of these bytes: polynomial 0x07, initial value 0x00, MSB first.
- R10: On abort, `resp_fcs` is the bitwise inverse of the R9 value. An unrecognised code therefore gives 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | One-cycle strobe: a decoded request is present |
| cmd_code | input | 8 | Command byte, domain in bits 1:0 |
| wr_len | input | 8 | Declared write length |
| rd_len | input | 8 | Declared read length |
| wr_data | input | 48 | Write payload, byte k at bits 8k+7:8k |
| frame_fcs_ok | input | 1 | Request FCS was correct |
| data_ready | input | 1 | Back-end reply data is available |
| rd_data | input | 32 | Back-end reply data, byte k at bits 8k+7:8k |
| resp_valid | output | 1 | One-cycle reply strobe |
| resp_abort | output | 1 | Reply is aborted (FCS inverted) |
| resp_has_cc | output | 1 | Reply starts with a completion code |
| resp_cc | output | 8 | Completion code |
| resp_fcs | output | 8 | FCS byte to transmit |
| resp_domain | output | 1 | Domain of the accepted command |

## Verification
Each of the five commands is sent in well-formed shape in both domains. This separates the per-command length table, the presence of a completion code and the length of the CRC span (zero, two or four data bytes after the code). The same codes are then spoiled one cause at a time:
- an unknown base code, or a domain field of 00 or 11
- a length pair shifted by one
- data not ready
- a bad request FCS
- an assured-write byte with some bits flipped

Each abort cause is thereby tied to the inverted FCS and to the 0x80 code. A second instance with a single domain shows that only domain-1 codes change outcome. Idle cycles with moving inputs show that the outputs hold between replies.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    typedef enum logic [2:0] {
        K_NONE,
        K_TEMP,
        K_CFG_RD,
        K_CFG_WR,
        K_MBX_TX,
        K_MBX_RX
    } cmd_kind_e;

    // required (write, read) lengths per command
    localparam logic [7:0] LEN_TEMP_WR   = 8'd1;
    localparam logic [7:0] LEN_TEMP_RD   = 8'd2;
    localparam logic [7:0] LEN_CFGRD_WR  = 8'd5;
    localparam logic [7:0] LEN_CFGRD_RD  = 8'd5;
    localparam logic [7:0] LEN_CFGWR_WR  = 8'd7;
    localparam logic [7:0] LEN_CFGWR_RD  = 8'd1;
    localparam logic [7:0] LEN_MBXTX_WR  = 8'd7;
    localparam logic [7:0] LEN_MBXTX_RD  = 8'd1;
    localparam logic [7:0] LEN_MBXRX_WR  = 8'd2;
    localparam logic [7:0] LEN_MBXRX_RD  = 8'd5;

    // payload sizing derived from the table
    localparam int unsigned WR_PAY_BYTES = int'(LEN_CFGWR_WR) - 1;
    localparam int unsigned AW_COVER     = WR_PAY_BYTES - 1;
    localparam int unsigned RD_DAT_BYTES = int'(LEN_CFGRD_RD) - 1;

    localparam logic [7:0] CC_PASS  = 8'h40;
    localparam logic [7:0] CC_FAIL  = 8'h80;
    localparam logic [7:0] CRC_POLY = 8'h07;

    function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] data);
        logic [7:0] c;
        c = crc ^ data;
        for (int i = 0; i < 8; i++) begin
            c = c[7] ? ((c << 1) ^ CRC_POLY) : (c << 1);
        end
        return c;
    endfunction

    typedef struct packed {
        logic       valid;
        logic       abort;
        logic       has_cc;
        logic [7:0] cc;
        logic [7:0] fcs;
        logic       domain;
    } resp_t;

endpackage

// File: rtl/sbr_cmd_decode.sv
module sbr_cmd_decode
    import sbr_pkg::*;
#(
    parameter bit DUAL_DOMAIN = 1'b1
) (
    input  logic [7:0] cmd_code,
    input  logic [7:0] wr_len,
    input  logic [7:0] rd_len,
    output cmd_kind_e  kind,
    output logic       code_ok,
    output logic       len_ok,
    output logic       has_cc,
    output logic       needs_data,
    output logic       assured,
    output logic       domain,
    output logic [7:0] resp_bytes
);

    cmd_kind_e  base_kind;
    logic       dom_ok;
    logic [7:0] need_wr;
    logic [7:0] need_rd;

    always_comb begin
        case (cmd_code[7:2])
            6'h00:   base_kind = K_TEMP;
            6'h30:   base_kind = K_CFG_RD;
            6'h31:   base_kind = K_CFG_WR;
            6'h34:   base_kind = K_MBX_TX;
            6'h35:   base_kind = K_MBX_RX;
            default: base_kind = K_NONE;
        endcase

        dom_ok = (cmd_code[1:0] == 2'b01) || (DUAL_DOMAIN && (cmd_code[1:0] == 2'b10));
        kind   = dom_ok ? base_kind : K_NONE;

        need_wr    = 8'd0;
        need_rd    = 8'd0;
        has_cc     = 1'b0;
        needs_data = 1'b0;
        assured    = 1'b0;
        case (kind)
            K_TEMP: begin
                need_wr    = LEN_TEMP_WR;
                need_rd    = LEN_TEMP_RD;
                needs_data = 1'b1;
            end
            K_CFG_RD: begin
                need_wr    = LEN_CFGRD_WR;
                need_rd    = LEN_CFGRD_RD;
                has_cc     = 1'b1;
                needs_data = 1'b1;
            end
            K_CFG_WR: begin
                need_wr = LEN_CFGWR_WR;
                need_rd = LEN_CFGWR_RD;
                has_cc  = 1'b1;
                assured = 1'b1;
            end
            K_MBX_TX: begin
                need_wr = LEN_MBXTX_WR;
                need_rd = LEN_MBXTX_RD;
                has_cc  = 1'b1;
                assured = 1'b1;
            end
            K_MBX_RX: begin
                need_wr    = LEN_MBXRX_WR;
                need_rd    = LEN_MBXRX_RD;
                has_cc     = 1'b1;
                needs_data = 1'b1;
            end
            default: ;
        endcase

        code_ok    = (kind != K_NONE);
        len_ok     = code_ok && (wr_len == need_wr) && (rd_len == need_rd);
        domain     = code_ok && cmd_code[1];
        resp_bytes = need_rd;
    end

endmodule

// File: rtl/sbr_aw_check.sv
module sbr_aw_check
    import sbr_pkg::*;
#(
    parameter int unsigned COVER = 5,
    localparam int unsigned PAY_BITS = (COVER + 1) * 8
) (
    input  logic [7:0]          cmd_code,
    input  logic [PAY_BITS-1:0] payload,
    output logic                aw_ok
);

    logic [7:0] chain [COVER+1];

    assign chain[0] = crc8_step(8'h00, cmd_code);

    for (genvar g = 0; g < COVER; g++) begin : g_step
        assign chain[g+1] = crc8_step(chain[g], payload[8*g +: 8]);
    end

    assign aw_ok = (payload[8*COVER +: 8] == chain[COVER]);

endmodule

// File: rtl/sbr_resp_fcs.sv
module sbr_resp_fcs
    import sbr_pkg::*;
#(
    parameter int unsigned DAT_BYTES = 4,
    localparam int unsigned DAT_BITS = DAT_BYTES * 8,
    localparam int unsigned SLOTS    = DAT_BYTES + 1
) (
    input  logic                has_cc,
    input  logic [7:0]          cc,
    input  logic [7:0]          n_bytes,
    input  logic [DAT_BITS-1:0] data,
    output logic [7:0]          crc
);

    logic [7:0] chain  [SLOTS+1];
    logic [7:0] stream [SLOTS];

    assign chain[0] = 8'h00;

    for (genvar g = 0; g < SLOTS; g++) begin : g_byte
        logic [7:0] shifted;
        logic [7:0] direct;
        if (g == 0) begin : g_first
            assign shifted = cc;
        end else begin : g_rest
            assign shifted = data[8*(g-1) +: 8];
        end
        if (g < DAT_BYTES) begin : g_in
            assign direct = data[8*g +: 8];
        end else begin : g_pad
            assign direct = 8'h00;
        end
        assign stream[g]  = has_cc ? shifted : direct;
        assign chain[g+1] = (8'(g) < n_bytes) ? crc8_step(chain[g], stream[g]) : chain[g];
    end

    assign crc = chain[SLOTS];

endmodule

// File: rtl/sbr_responder.sv
module sbr_responder
    import sbr_pkg::*;
#(
    parameter bit DUAL_DOMAIN = 1'b1,
    localparam int unsigned WR_BITS = WR_PAY_BYTES * 8,
    localparam int unsigned RD_BITS = RD_DAT_BYTES * 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_valid,
    input  logic [7:0]         cmd_code,
    input  logic [7:0]         wr_len,
    input  logic [7:0]         rd_len,
    input  logic [WR_BITS-1:0] wr_data,
    input  logic               frame_fcs_ok,
    input  logic               data_ready,
    input  logic [RD_BITS-1:0] rd_data,
    output logic               resp_valid,
    output logic               resp_abort,
    output logic               resp_has_cc,
    output logic [7:0]         resp_cc,
    output logic [7:0]         resp_fcs,
    output logic               resp_domain
);

    cmd_kind_e  kind;
    logic       code_ok, len_ok, has_cc, needs_data, assured, domain;
    logic [7:0] resp_bytes;
    logic       aw_ok;
    logic       fail;
    logic [7:0] cc_sel;
    logic [7:0] crc_good;
    resp_t      r_d, r_q;

    sbr_cmd_decode #(.DUAL_DOMAIN(DUAL_DOMAIN)) u_dec (
        .cmd_code   (cmd_code),
        .wr_len     (wr_len),
        .rd_len     (rd_len),
        .kind       (kind),
        .code_ok    (code_ok),
        .len_ok     (len_ok),
        .has_cc     (has_cc),
        .needs_data (needs_data),
        .assured    (assured),
        .domain     (domain),
        .resp_bytes (resp_bytes)
    );

    sbr_aw_check #(.COVER(AW_COVER)) u_aw (
        .cmd_code (cmd_code),
        .payload  (wr_data),
        .aw_ok    (aw_ok)
    );

    sbr_resp_fcs #(.DAT_BYTES(RD_DAT_BYTES)) u_fcs (
        .has_cc  (has_cc),
        .cc      (cc_sel),
        .n_bytes (resp_bytes),
        .data    (rd_data),
        .crc     (crc_good)
    );

    always_comb begin
        fail = !code_ok || !len_ok || !frame_fcs_ok
            || (needs_data && !data_ready)
            || (assured && !aw_ok);
        cc_sel = fail ? CC_FAIL : CC_PASS;

        r_d       = r_q;
        r_d.valid = 1'b0;
        if (frame_valid) begin
            r_d.valid  = 1'b1;
            r_d.abort  = fail;
            r_d.has_cc = has_cc;
            r_d.cc     = has_cc ? cc_sel : 8'h00;
            r_d.fcs    = fail ? ~crc_good : crc_good;
            r_d.domain = domain;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign resp_valid  = r_q.valid;
    assign resp_abort  = r_q.abort;
    assign resp_has_cc = r_q.has_cc;
    assign resp_cc     = r_q.cc;
    assign resp_fcs    = r_q.fcs;
    assign resp_domain = r_q.domain;

    // R1
    strobe_follows_frame_chk: assert property (@(posedge clk) disable iff (rst)
        frame_valid |=> resp_valid);

    // R1
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_valid |=> !resp_valid && $stable(resp_fcs) && $stable(resp_cc));

    // R2
    unknown_code_abort_chk: assert property (@(posedge clk) disable iff (rst)
        frame_valid && !code_ok |=> resp_abort && !resp_has_cc && !resp_domain);

    // R5
    not_ready_abort_chk: assert property (@(posedge clk) disable iff (rst)
        frame_valid && needs_data && !data_ready |=> resp_abort);

    // R7
    bad_frame_abort_chk: assert property (@(posedge clk) disable iff (rst)
        frame_valid && !frame_fcs_ok |=> resp_abort);

    // R8
    temp_no_cc_chk: assert property (@(posedge clk) disable iff (rst)
        frame_valid && (kind == K_TEMP) |=> !resp_has_cc && (resp_cc == 8'h00));

endmodule

// File: tb/sbr_responder_test.sv
module sbr_responder_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_valid = 1'b0;
    logic [7:0]  cmd_code = 8'h00;
    logic [7:0]  wr_len = 8'h00;
    logic [7:0]  rd_len = 8'h00;
    logic [47:0] wr_data = '0;
    logic        frame_fcs_ok = 1'b0;
    logic        data_ready = 1'b0;
    logic [31:0] rd_data = '0;

    logic        resp_valid, resp_abort, resp_has_cc, resp_domain;
    logic [7:0]  resp_cc, resp_fcs;
    logic        sd_valid, sd_abort, sd_has_cc, sd_domain;
    logic [7:0]  sd_cc, sd_fcs;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbr_responder uut (
        .clk(clk), .rst(rst), .frame_valid(frame_valid), .cmd_code(cmd_code),
        .wr_len(wr_len), .rd_len(rd_len), .wr_data(wr_data),
        .frame_fcs_ok(frame_fcs_ok), .data_ready(data_ready), .rd_data(rd_data),
        .resp_valid(resp_valid), .resp_abort(resp_abort), .resp_has_cc(resp_has_cc),
        .resp_cc(resp_cc), .resp_fcs(resp_fcs), .resp_domain(resp_domain)
    );

    sbr_responder #(.DUAL_DOMAIN(1'b0)) uut_sd (
        .clk(clk), .rst(rst), .frame_valid(frame_valid), .cmd_code(cmd_code),
        .wr_len(wr_len), .rd_len(rd_len), .wr_data(wr_data),
        .frame_fcs_ok(frame_fcs_ok), .data_ready(data_ready), .rd_data(rd_data),
        .resp_valid(sd_valid), .resp_abort(sd_abort), .resp_has_cc(sd_has_cc),
        .resp_cc(sd_cc), .resp_fcs(sd_fcs), .resp_domain(sd_domain)
    );

    // bit-serial reference CRC, polynomial 0x07, MSB first
    function automatic logic [7:0] ref_crc(input logic [7:0] crc, input logic [7:0] b);
        logic [7:0] r;
        r = crc;
        for (int i = 7; i >= 0; i--) begin
            logic fb;
            fb = r[7] ^ b[i];
            r  = {r[6:0], 1'b0};
            if (fb) r = r ^ 8'h07;
        end
        return r;
    endfunction

    function automatic logic [47:0] mk_write(input logic [7:0] c, input logic [39:0] body, input bit good);
        logic [7:0] s;
        s = ref_crc(8'h00, c);
        for (int k = 0; k < 5; k++) s = ref_crc(s, body[8*k +: 8]);
        if (!good) s = s ^ 8'h5A;
        return {s, body};
    endfunction

    task automatic check8(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] c, input logic [7:0] wl, input logic [7:0] rl,
                        input logic [47:0] wd, input logic fok, input logic dr, input logic [31:0] rd);
        @(negedge clk);
        cmd_code     = c;
        wr_len       = wl;
        rd_len       = rl;
        wr_data      = wd;
        frame_fcs_ok = fok;
        data_ready   = dr;
        rd_data      = rd;
        frame_valid  = 1'b1;
        @(negedge clk);
        frame_valid  = 1'b0;
    endtask

    task automatic expect_resp(input string req, input logic ab, input logic hc, input int ndata,
                               input logic [31:0] rd, input logic dom);
        logic [7:0] cc;
        logic [7:0] crc;
        cc  = hc ? (ab ? 8'h80 : 8'h40) : 8'h00;
        crc = 8'h00;
        if (hc) crc = ref_crc(crc, cc);
        for (int k = 0; k < ndata; k++) crc = ref_crc(crc, rd[8*k +: 8]);
        if (ab) crc = ~crc;
        check8(req, "valid",  {7'd0, resp_valid},  8'd1);
        check8(req, "abort",  {7'd0, resp_abort},  {7'd0, ab});
        check8(req, "has_cc", {7'd0, resp_has_cc}, {7'd0, hc});
        check8(req, "cc",     resp_cc,             cc);
        check8(req, "fcs",    resp_fcs,            crc);
        check8(req, "domain", {7'd0, resp_domain}, {7'd0, dom});
    endtask

    task automatic strobe_ends(input string req);
        @(negedge clk);
        check8(req, "valid after strobe", {7'd0, resp_valid}, 8'd0);
    endtask

    task automatic t_reset;
        check8("R1", "reset valid", {7'd0, resp_valid}, 8'd0);
        check8("R1", "reset abort", {7'd0, resp_abort}, 8'd0);
        check8("R1", "reset cc",    resp_cc,            8'h00);
        check8("R1", "reset fcs",   resp_fcs,           8'h00);
    endtask

    task automatic t_reads;
        send(8'h01, 8'd1, 8'd2, '0, 1'b1, 1'b1, 32'h0000_3A91);
        expect_resp("R9 temp d0", 1'b0, 1'b0, 2, 32'h0000_3A91, 1'b0);
        strobe_ends("R1");
        send(8'h02, 8'd1, 8'd2, '0, 1'b1, 1'b1, 32'h0000_77C4);
        expect_resp("R8 temp d1", 1'b0, 1'b0, 2, 32'h0000_77C4, 1'b1);
        send(8'hC2, 8'd5, 8'd5, 48'h0000_1234_5678, 1'b1, 1'b1, 32'hDEAD_BEEF);
        expect_resp("R2 cfgrd d1", 1'b0, 1'b1, 4, 32'hDEAD_BEEF, 1'b1);
        send(8'hD5, 8'd2, 8'd5, 48'h3, 1'b1, 1'b1, 32'h0102_0304);
        expect_resp("R9 mbxget d0", 1'b0, 1'b1, 4, 32'h0102_0304, 1'b0);
    endtask

    task automatic t_writes;
        send(8'hC5, 8'd7, 8'd1, mk_write(8'hC5, 40'h11_2233_4455, 1'b1), 1'b1, 1'b1, 32'hFFFF_FFFF);
        expect_resp("R6 cfgwr good", 1'b0, 1'b1, 0, 32'h0, 1'b0);
        send(8'hD2, 8'd7, 8'd1, mk_write(8'hD2, 40'hA0_B1C2_D3E4, 1'b1), 1'b1, 1'b0, 32'h0);
        expect_resp("R5 mbxsend not-ready ignored", 1'b0, 1'b1, 0, 32'h0, 1'b1);
        send(8'hC5, 8'd7, 8'd1, mk_write(8'hC5, 40'h11_2233_4455, 1'b0), 1'b1, 1'b1, 32'h0);
        expect_resp("R6 cfgwr bad aw", 1'b1, 1'b1, 0, 32'h0, 1'b0);
        send(8'hD1, 8'd7, 8'd1, mk_write(8'hD1, 40'h00_0000_0001, 1'b0), 1'b1, 1'b1, 32'h0);
        expect_resp("R10 mbxsend bad aw", 1'b1, 1'b1, 0, 32'h0, 1'b0);
    endtask

    task automatic t_unknown;
        send(8'h03, 8'd1, 8'd2, '0, 1'b1, 1'b1, 32'h1234);
        expect_resp("R10 code 03", 1'b1, 1'b0, 0, 32'h0, 1'b0);
        check8("R10", "fcs of empty abort", resp_fcs, 8'hFF);
        send(8'hC0, 8'd5, 8'd5, '0, 1'b1, 1'b1, 32'h0);
        expect_resp("R2 domain 00", 1'b1, 1'b0, 0, 32'h0, 1'b0);
        send(8'h11, 8'd1, 8'd2, '0, 1'b1, 1'b1, 32'h0);
        expect_resp("R2 base 10", 1'b1, 1'b0, 0, 32'h0, 1'b0);
        send(8'hE1, 8'd1, 8'd1, '0, 1'b1, 1'b1, 32'h0);
        expect_resp("R2 base E0", 1'b1, 1'b0, 0, 32'h0, 1'b0);
    endtask

    task automatic t_lengths;
        send(8'hC1, 8'd6, 8'd5, '0, 1'b1, 1'b1, 32'hCAFE_F00D);
        expect_resp("R4 cfgrd wr+1", 1'b1, 1'b1, 4, 32'hCAFE_F00D, 1'b0);
        send(8'hC1, 8'd5, 8'd4, '0, 1'b1, 1'b1, 32'hCAFE_F00D);
        expect_resp("R4 cfgrd rd-1", 1'b1, 1'b1, 4, 32'hCAFE_F00D, 1'b0);
        send(8'h01, 8'd1, 8'd3, '0, 1'b1, 1'b1, 32'h0000_5566);
        expect_resp("R4 temp rd+1", 1'b1, 1'b0, 2, 32'h0000_5566, 1'b0);
        send(8'hC6, 8'd6, 8'd1, mk_write(8'hC6, 40'h1, 1'b1), 1'b1, 1'b1, 32'h0);
        expect_resp("R4 cfgwr wr-1", 1'b1, 1'b1, 0, 32'h0, 1'b1);
    endtask

    task automatic t_ready_and_fcs;
        send(8'hC1, 8'd5, 8'd5, '0, 1'b1, 1'b0, 32'h8899_AABB);
        expect_resp("R5 cfgrd not ready", 1'b1, 1'b1, 4, 32'h8899_AABB, 1'b0);
        send(8'h01, 8'd1, 8'd2, '0, 1'b1, 1'b0, 32'h0000_0042);
        expect_resp("R5 temp not ready", 1'b1, 1'b0, 2, 32'h0000_0042, 1'b0);
        send(8'hD5, 8'd2, 8'd5, '0, 1'b0, 1'b1, 32'h0102_0304);
        expect_resp("R7 bad request fcs", 1'b1, 1'b1, 4, 32'h0102_0304, 1'b0);
    endtask

    task automatic t_hold;
        logic [7:0] fcs0;
        logic [7:0] cc0;
        send(8'hC1, 8'd5, 8'd5, '0, 1'b1, 1'b1, 32'h1357_9BDF);
        expect_resp("R1 hold base", 1'b0, 1'b1, 4, 32'h1357_9BDF, 1'b0);
        fcs0 = resp_fcs;
        cc0  = resp_cc;
        cmd_code   = 8'h03;
        rd_data    = 32'h0;
        data_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check8("R1", "idle valid", {7'd0, resp_valid}, 8'd0);
        check8("R1", "idle fcs held", resp_fcs, fcs0);
        check8("R1", "idle cc held", resp_cc, cc0);
    endtask

    task automatic t_single_domain;
        send(8'hC1, 8'd5, 8'd5, '0, 1'b1, 1'b1, 32'h0A0B_0C0D);
        check8("R3", "single d0 abort", {7'd0, sd_abort}, 8'd0);
        check8("R3", "single d0 cc", sd_cc, 8'h40);
        send(8'hC2, 8'd5, 8'd5, '0, 1'b1, 1'b1, 32'h0A0B_0C0D);
        check8("R3", "single d1 valid", {7'd0, sd_valid}, 8'd1);
        check8("R3", "single d1 abort", {7'd0, sd_abort}, 8'd1);
        check8("R3", "single d1 has_cc", {7'd0, sd_has_cc}, 8'd0);
        check8("R3", "single d1 fcs", sd_fcs, 8'hFF);
        check8("R3", "single d1 domain", {7'd0, sd_domain}, 8'd0);
        check8("R3", "dual d1 accepted", {7'd0, resp_abort}, 8'd0);
        check8("R3", "dual d1 domain", {7'd0, resp_domain}, 8'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_reads();
        t_writes();
        t_unknown();
        t_lengths();
        t_ready_and_fcs();
        t_hold();
        t_single_domain();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule